// File: doc/BRIEF.md
# Masked Change-Detect Interrupt Controller

This block watches a bank of already-filtered channel levels and turns level changes into a latched, software-readable interrupt. A channel can raise an interrupt only when two conditions hold. First, its channel group is set to input function. Second, its own enable bit is set. When both hold, any rise or fall of the channel's level, compared with its level on the previous clock, sets that channel's flag. Flags gather until software clears them. An active-low interrupt line stays low while any flag is set.

The register layer above the block writes the enable mask and the per-group function setting. It also forwards the clear command and reads back the flags and the mask. A clear is a single write with the clear bit at 1, and it empties all flags at once. The clear bit is not stored, so it reads as 0 afterwards and needs no second write. If a new change arrives on the same edge as a clear, that change's flag survives.

The control state machine has two states. ST_IDLE means no flag is set and the line is high. ST_PENDING means at least one flag is set and the line is low. There are four transitions:
- ST_IDLE to ST_PENDING when any eligible change arrives.
- ST_PENDING to ST_IDLE when a clear arrives with no eligible change on the same edge.
- ST_PENDING stays in ST_PENDING otherwise.
- ST_IDLE stays in ST_IDLE otherwise.

Top module: `chgirq_ctrl`

## Requirements
- R1: After reset, `irq_flags` is 0, `en_mask` is 0 and `irq_n` is 1.
- R2: A rising level on channel i, when that channel is eligible, sets `irq_flags[i]` and drives `irq_n` low at the first rising clock edge after the new level is presented.
- R3: A falling level on an eligible channel sets its flag and drives `irq_n` low with the same one-edge timing as R2.
- R4: A change on a channel whose `en_mask` bit is 0 sets no flag and leaves `irq_n` unchanged.
- R5: Channel group g covers channels g*4 to g*4+3. A change on a channel whose group has `grp_input[g]` = 0 (output function) sets no flag, even when the channel is enabled.
- R6: Flags from different channels and cycles accumulate. They stay set with no clear, and `irq_n` is low exactly while any flag is 1.
- R7: A pulse on `ctl2_wr` with `ctl2_clr` = 1 clears every flag and releases `irq_n` high at that edge. A pulse with `ctl2_clr` = 0 changes nothing.
- R8: When an eligible change and a clear hit the same edge, the changing channel's flag is set afterwards and all other flags are cleared.
- R9: The clear bit is not stored. After one clear write, later eligible changes latch normally with no further write.
- R10: Clearing an `en_mask` bit leaves an already-set flag in place.
- R11: A level held constant sets no flag, however long it is held.
- R12: A pulse on `en_wr` loads `en_wdata` into `en_mask`, and the value is visible after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_in | input | 8 | Filtered channel levels |
| grp_input | input | 2 | Per four-channel group: 1 = input function, 0 = output function |
| en_wr | input | 1 | Write strobe for the enable mask |
| en_wdata | input | 8 | Enable mask data, 1 = channel takes part |
| ctl2_wr | input | 1 | Write strobe for the clear command |
| ctl2_clr | input | 1 | Clear bit of the control write, 1 = clear all flags |
| en_mask | output | 8 | Current enable mask |
| irq_flags | output | 8 | Latched change flags, one per channel |
| irq_n | output | 1 | Active-low interrupt, low while any flag is set |

## Verification
Every result is due one rising edge after its stimulus. This covers a flag and `irq_n` after a level change, the cleared state after a clear write, and the new mask after an enable write. The previous level is held in a register, so a change presented before an edge is seen at that edge. The bench drives every input on the falling clock edge and samples outputs on the next falling edge, half a period after the edge that made them. For the cases that must show no effect, the bench holds the stimulus for several edges and samples each time.

// File: rtl/chgirq_pkg.sv
package chgirq_pkg;
    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_PENDING = 1'b1
    } irq_state_e;
endpackage

// File: rtl/chgirq_cfg.sv
module chgirq_cfg #(
    parameter int NCH = 8,
    parameter int GRP = 4,
    localparam int NGRP = NCH / GRP
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_wr,
    input  logic [NCH-1:0]  en_wdata,
    input  logic [NGRP-1:0] grp_input,
    output logic [NCH-1:0]  en_mask,
    output logic [NCH-1:0]  in_mask
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     en_mask <= '0;
        else if (en_wr) en_mask <= en_wdata;
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign in_mask[g*GRP +: GRP] = {GRP{grp_input[g]}};
    end
endmodule

// File: rtl/chgirq_detect.sv
module chgirq_detect #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] q_in,
    input  logic [NCH-1:0] en_mask,
    input  logic [NCH-1:0] in_mask,
    output logic [NCH-1:0] elig
);
    logic [NCH-1:0] q_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_prev <= '0;
        else        q_prev <= q_in;
    end

    always_comb elig = (q_in ^ q_prev) & en_mask & in_mask;

    // R4 R5
    elig_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((elig & ~(en_mask & in_mask)) == '0));

    // R11
    steady_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(q_in) |=> ((elig & ~(q_in ^ $past(q_in))) == '0));
endmodule

// File: rtl/chgirq_latch.sv
module chgirq_latch #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] elig,
    input  logic           clr,
    output logic [NCH-1:0] flags
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= (clr ? '0 : flags) | elig;
    end

    // R7
    clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && elig == '0) |=> (flags == '0));

    // R8
    new_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (elig != '0) |=> ((flags & $past(elig)) == $past(elig)));

    // R6 R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (($past(flags) & ~flags) == '0));

    // R4
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & ~$past(flags) & ~$past(elig)) == '0));
endmodule

// File: rtl/chgirq_fsm.sv
module chgirq_fsm
    import chgirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_new,
    input  logic clr,
    output logic irq_n
);
    irq_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (any_new)         state_nx = ST_PENDING;
            ST_PENDING: if (clr && !any_new) state_nx = ST_IDLE;
            default:                         state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb irq_n = (state != ST_PENDING);

    // R2 R3
    raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_new |=> !irq_n);
endmodule

// File: rtl/chgirq_ctrl.sv
module chgirq_ctrl #(
    parameter int NCH = 8,
    parameter int GRP = 4,
    localparam int NGRP = NCH / GRP
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  q_in,
    input  logic [NGRP-1:0] grp_input,
    input  logic            en_wr,
    input  logic [NCH-1:0]  en_wdata,
    input  logic            ctl2_wr,
    input  logic            ctl2_clr,
    output logic [NCH-1:0]  en_mask,
    output logic [NCH-1:0]  irq_flags,
    output logic            irq_n
);
    logic [NCH-1:0] in_mask;
    logic [NCH-1:0] elig;
    logic           clr;

    assign clr = ctl2_wr & ctl2_clr;

    chgirq_cfg #(.NCH(NCH), .GRP(GRP)) u_cfg (
        .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata),
        .grp_input(grp_input), .en_mask(en_mask), .in_mask(in_mask)
    );

    chgirq_detect #(.NCH(NCH)) u_detect (
        .clk(clk), .rst_n(rst_n), .q_in(q_in), .en_mask(en_mask),
        .in_mask(in_mask), .elig(elig)
    );

    chgirq_latch #(.NCH(NCH)) u_latch (
        .clk(clk), .rst_n(rst_n), .elig(elig), .clr(clr), .flags(irq_flags)
    );

    chgirq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .any_new(|elig), .clr(clr), .irq_n(irq_n)
    );

    // R6
    line_matches_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n == (irq_flags == '0));

    // R12
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr |=> (en_mask == $past(en_wdata)));
endmodule

// File: tb/chgirq_ctrl_bench.sv
module chgirq_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] q_in = '0;
    logic [1:0] grp_input = 2'b11;
    logic       en_wr = 1'b0;
    logic [7:0] en_wdata = '0;
    logic       ctl2_wr = 1'b0;
    logic       ctl2_clr = 1'b0;
    logic [7:0] en_mask, irq_flags;
    logic       irq_n;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chgirq_ctrl u_chgirq_ctrl (
        .clk(clk), .rst_n(rst_n), .q_in(q_in), .grp_input(grp_input),
        .en_wr(en_wr), .en_wdata(en_wdata), .ctl2_wr(ctl2_wr),
        .ctl2_clr(ctl2_clr), .en_mask(en_mask), .irq_flags(irq_flags),
        .irq_n(irq_n)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic chk_out(string req, logic [7:0] f, logic n);
        chk(req, irq_flags, f);
        chk(req, {7'b0, irq_n}, {7'b0, n});
    endtask

    task automatic write_en(logic [7:0] v);
        en_wr = 1'b1; en_wdata = v;
        tick();
        en_wr = 1'b0;
    endtask

    task automatic do_clear(logic b);
        ctl2_wr = 1'b1; ctl2_clr = b;
        tick();
        ctl2_wr = 1'b0; ctl2_clr = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) tick();
        chk_out("R1", 8'h00, 1'b1);
        chk("R1", en_mask, 8'h00);
        rst_n = 1'b1;
        tick();
        chk_out("R1", 8'h00, 1'b1);
    endtask

    task automatic t_mask();
        write_en(8'hA5);
        chk("R12", en_mask, 8'hA5);
    endtask

    task automatic t_rise_fall();
        q_in[0] = 1'b1; tick();
        chk_out("R2", 8'h01, 1'b0);
        do_clear(1'b1);
        chk_out("R7", 8'h00, 1'b1);
        q_in[0] = 1'b0; tick();
        chk_out("R3", 8'h01, 1'b0);
        do_clear(1'b1);
    endtask

    task automatic t_disabled();
        q_in[1] = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk_out("R4", 8'h00, 1'b1);
        end
    endtask

    task automatic t_output_group();
        grp_input = 2'b01;
        q_in[7] = 1'b1; tick();
        chk_out("R5", 8'h00, 1'b1);
        q_in[2] = 1'b1; tick();
        chk_out("R5", 8'h04, 1'b0);
        do_clear(1'b1);
        grp_input = 2'b11;
        tick();
    endtask

    task automatic t_accumulate();
        q_in[0] = 1'b1; tick();
        tick();
        q_in[5] = 1'b1; tick();
        chk_out("R6", 8'h21, 1'b0);
        repeat (3) tick();
        chk_out("R6", 8'h21, 1'b0);
        do_clear(1'b0);
        chk_out("R7", 8'h21, 1'b0);
        do_clear(1'b1);
        chk_out("R7", 8'h00, 1'b1);
    endtask

    task automatic t_steady();
        for (int i = 0; i < 5; i++) begin
            tick();
            chk_out("R11", 8'h00, 1'b1);
        end
    endtask

    task automatic t_race();
        q_in[2] = 1'b0; tick();
        chk_out("R8", 8'h04, 1'b0);
        q_in[0] = 1'b0;
        do_clear(1'b1);
        chk_out("R8", 8'h01, 1'b0);
        tick();
        chk_out("R9", 8'h01, 1'b0);
        do_clear(1'b1);
        q_in[5] = 1'b0; tick();
        chk_out("R9", 8'h20, 1'b0);
    endtask

    task automatic t_disable_after();
        write_en(8'h00);
        chk_out("R10", 8'h20, 1'b0);
        q_in[5] = 1'b1; tick();
        chk_out("R10", 8'h20, 1'b0);
        do_clear(1'b1);
        chk_out("R10", 8'h00, 1'b1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_mask();
        t_rise_fall();
        t_disabled();
        t_output_group();
        t_accumulate();
        t_steady();
        t_race();
        t_disable_after();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule